// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block holds the exception part of a 32-bit floating-point status word. When an arithmetic operation finishes, the arithmetic unit pulses `op_valid` with a 5-bit vector of the exceptions that operation raised. The block ORs those bits into sticky flags in the top five bits of the word. In the same update it compares the new vector with the trap enables in the bottom five bits. If any raised exception is enabled, it issues a one-cycle trap request.

Software can replace the whole word with one write. The block also sends out the rounding-mode field and the denormal-flush control as decoded outputs, so the arithmetic unit can consume them directly.

Top module: `fp_flag_accum`

## Requirements
- R1: Reset clears the status word to zero and holds `trap_req` low.
- R2: Raised-flag bit i (0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) sets status bit 27+i in the cycle after the valid operation.
- R3: Sticky flags accumulate across operations. An operation update never clears a status bit.
- R4: A valid operation with an all-zero flag vector leaves the status word unchanged and raises no trap.
- R5: `trap_req` pulses for exactly one cycle, in the same cycle as the status update. It pulses when the operation's flag vector ANDed with status bits 4:0 (the enables, same bit order as R2) is non-zero.
- R6: Flags from one operation do not carry into the next. An operation only traps on its own flags, not on flags accumulated earlier.
- R7: A software write (`sw_we`) loads `sw_wdata` into the whole status word in the next cycle and raises no trap.
- R8: When a software write and a valid operation arrive in the same cycle, the write wins. The operation's flags are dropped and no trap is raised.
- R9: `round_mode` equals status bits 10:9 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity). `flush_den` equals status bit 5.
- R10: When `op_valid` is low and no write occurs, `op_flags` is ignored: the status word is unchanged and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation-complete pulse |
| op_flags | input | 5 | Exceptions raised by the operation |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| status | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle trap request |
| round_mode | output | 2 | Decoded rounding mode |
| flush_den | output | 1 | Denormal flush enable |

## Verification
The flag vector is driven one-hot, with each bit on its own, to expose any mis-ordering of the flag-to-bit mapping. Mixed vectors across successive operations show whether the flags are sticky. The all-zero vector separates "unchanged" from "rewritten".

Trap cases pair an enabled flag with a disabled one. A trapping operation is followed by a flag-free or disabled-flag operation, to tell current-operation trapping apart from trapping on accumulated flags. Writes that coincide with operations check the priority, and a sweep of rounding-field values checks the decode.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;
    localparam int WORD_W = 32;
    localparam int NFLAG  = 5;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } round_e;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic              trap;
    } accum_state_t;
endpackage

// File: rtl/flag_place.sv
module flag_place #(
    parameter int WORD_W = 32,
    parameter int NFLAG  = 5
) (
    input  logic [NFLAG-1:0]  flags_in,
    output logic [WORD_W-1:0] placed
);
    localparam int BASE = WORD_W - NFLAG;

    genvar i;
    generate
        for (i = 0; i < WORD_W; i++) begin : g_bit
            if (i >= BASE) begin : g_flag
                assign placed[i] = flags_in[i-BASE];
            end else begin : g_zero
                assign placed[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/trap_detect.sv
module trap_detect #(
    parameter int NFLAG = 5
) (
    input  logic [NFLAG-1:0] flags_in,
    input  logic [NFLAG-1:0] enables,
    output logic             hit
);
    assign hit = |(flags_in & enables);
endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import fpflag_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RM_LSB = 9,
    parameter int FTZ_BIT = 5
) (
    input  logic [WORD_W-1:0] word,
    output round_e            rmode,
    output logic              ftz
);
    always_comb begin
        unique case (word[RM_LSB+1:RM_LSB])
            2'd1:    rmode = RM_TO_ZERO;
            2'd2:    rmode = RM_UP;
            2'd3:    rmode = RM_DOWN;
            default: rmode = RM_NEAR_EVEN;
        endcase
        ftz = word[FTZ_BIT];
    end
endmodule

// File: rtl/fp_flag_accum.sv
module fp_flag_accum
    import fpflag_pkg::*;
#(
    parameter int RM_LSB  = 9,
    parameter int FTZ_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [NFLAG-1:0]  op_flags,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] status,
    output logic              trap_req,
    output logic [1:0]        round_mode,
    output logic              flush_den
);
    accum_state_t state_d, state_q;
    logic [WORD_W-1:0] placed;
    logic              enab_hit;
    round_e            rm_dec;
    logic              ftz_dec;

    flag_place #(.WORD_W(WORD_W), .NFLAG(NFLAG)) u_place (
        .flags_in (op_flags),
        .placed   (placed)
    );

    trap_detect #(.NFLAG(NFLAG)) u_trap (
        .flags_in (op_flags),
        .enables  (state_q.status[NFLAG-1:0]),
        .hit      (enab_hit)
    );

    mode_decode #(.WORD_W(WORD_W), .RM_LSB(RM_LSB), .FTZ_BIT(FTZ_BIT)) u_mode (
        .word  (state_q.status),
        .rmode (rm_dec),
        .ftz   (ftz_dec)
    );

    always_comb begin
        state_d      = state_q;
        state_d.trap = 1'b0;
        if (sw_we) begin
            state_d.status = sw_wdata;
        end else if (op_valid) begin
            state_d.status = state_q.status | placed;
            state_d.trap   = enab_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status     = state_q.status;
    assign trap_req   = state_q.trap;
    assign round_mode = rm_dec;
    assign flush_den  = ftz_dec;

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_we) |-> ((status & $past(status)) == $past(status)));

    // R5
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid && !sw_we && ((op_flags & status[NFLAG-1:0]) != '0)));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_we) |-> (status == $past(sw_wdata) && !trap_req));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!op_valid && !sw_we) |-> ($stable(status) && !trap_req));
endmodule

// File: tb/fp_flag_accum_bench.sv
module fp_flag_accum_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [4:0]  op_flags;
    logic        sw_we;
    logic [31:0] sw_wdata;
    logic [31:0] status;
    logic        trap_req;
    logic [1:0]  round_mode;
    logic        flush_den;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_status;
    logic        m_trap;

    always #4 clk = ~clk;

    fp_flag_accum u_fp_flag_accum (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .status(status), .trap_req(trap_req),
        .round_mode(round_mode), .flush_den(flush_den)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(req, "status", status, m_status);
        chk(req, "trap", {31'd0, trap_req}, {31'd0, m_trap});
        chk("R9", "round_mode", {30'd0, round_mode}, {30'd0, m_status[10:9]});
        chk("R9", "flush_den", {31'd0, flush_den}, {31'd0, m_status[5]});
    endtask

    task automatic step(input string req, input bit v, input logic [4:0] f, input bit we, input logic [31:0] wd);
        op_valid = v; op_flags = f; sw_we = we; sw_wdata = wd;
        if (we) begin
            m_trap = 1'b0; m_status = wd;
        end else if (v) begin
            m_trap = (f & m_status[4:0]) != 5'd0;
            m_status = m_status | ({27'd0, f} << 27);
        end else begin
            m_trap = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_flags = '0; sw_we = 1'b0; sw_wdata = '0;
        m_status = '0; m_trap = 1'b0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R2: each flag alone lands in its own bit
        for (int i = 0; i < 5; i++) begin
            step("R7", 0, '0, 1, 32'h0);
            step("R2", 1, 5'(1 << i), 0, '0);
            chk("R2", "placed bit", status, 32'h1 << (27 + i));
        end

        // R3: accumulation
        step("R7", 0, '0, 1, 32'h0);
        step("R3", 1, 5'b00011, 0, '0);
        step("R3", 1, 5'b10100, 0, '0);
        step("R3", 1, 5'b00001, 0, '0);
        chk("R3", "accumulated", status, 32'hB800_0000);

        // R4: zero flags
        step("R4", 1, 5'b00000, 0, '0);

        // R5: enabled vs disabled
        step("R7", 0, '0, 1, 32'h0000_0004);
        step("R5", 1, 5'b00001, 0, '0);
        chk("R5", "no trap on disabled", {31'd0, trap_req}, 32'd0);
        step("R5", 1, 5'b00100, 0, '0);
        chk("R5", "trap on enabled", {31'd0, trap_req}, 32'd1);
        // R6: next op does not trap on old flags
        step("R6", 1, 5'b00000, 0, '0);
        chk("R6", "no carry", {31'd0, trap_req}, 32'd0);
        step("R6", 1, 5'b00010, 0, '0);
        chk("R6", "no carry disabled", {31'd0, trap_req}, 32'd0);
        step("R5", 1, 5'b11111, 0, '0);
        step("R5", 0, '0, 0, '0);

        // R10: flags without valid
        step("R7", 0, '0, 1, 32'h0000_001F);
        step("R10", 0, 5'b11111, 0, '0);
        chk("R10", "ignored", status, 32'h0000_001F);

        // R8: write wins
        step("R8", 1, 5'b11111, 1, 32'h1234_0000);
        chk("R8", "write wins trap", {31'd0, trap_req}, 32'd0);

        // R7 / R9: rounding field sweep
        for (int r = 0; r < 4; r++) begin
            step("R7", 0, '0, 1, (32'(r) << 9) | ((r % 2 == 1) ? 32'h20 : 32'h0));
            chk("R9", "rm value", {30'd0, round_mode}, 32'(r));
        end
        step("R7", 0, '0, 1, 32'hFFFF_FFFF);
        step("R3", 1, 5'b00000, 0, '0);

        // R1: reset mid-run
        rst_n = 1'b0;
        m_status = '0; m_trap = 1'b0;
        @(posedge clk); @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule